// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block accepts a serial bit stream and presents it as a parallel word. It has two register ranks. A shift chain of `WIDTH` stages takes one bit from `ser_in` on each shift event. A holding rank copies the whole chain on each store event and drives the parallel outputs. The last chain stage is also brought out on `ser_out`, so several instances can be chained: the `ser_out` of one feeds the `ser_in` of the next, and all of them share the shift and store strobes.

The whole block runs on a single system clock, `clk`. The shift and store strobes are plain level inputs. Each one passes through a synchronizer and a two-state edge machine. The machine starts in `ARMED`. When it sees the synchronized level high, it emits a one-cycle pulse and moves to `SPENT`. It returns to `ARMED` once the level is seen low again. An asynchronous active-low clear zeroes only the shift chain. The system reset `rst_n` zeroes every register.

The output enable works as a drive vector rather than as real tri-state pads. A `par_drive` bit of 0 means that output pin is high-impedance, and the integrating level resolves the pad from it. If the two strobes are tied together, the holding rank takes the chain contents from before that same shift, so the parallel outputs trail the chain by one bit.

Top module: `sipo_latch_reg`

## Requirements
- R1: Each rising edge detected on `shift_clk` loads `ser_in` into stage 0 and moves stage i into stage i+1, for every i below `WIDTH-1`.
- R2: Each rising edge detected on `store_clk` copies all `WIDTH` chain stages in parallel into the holding rank. Stage i goes to `par_data[i]`.
- R3: When the shift and store edges are detected in the same cycle, the holding rank receives the chain contents as they were before that shift.
- R4: Asserting `clr_n` low zeroes all chain stages at once, without waiting for `clk`. The holding rank and `par_data` keep their values.
- R5: `ser_out` always equals the last chain stage. After a shift, it shows the value that stage `WIDTH-2` held before the shift.
- R6: While `oe_n` is 0, `par_drive` is all ones and `par_data` shows the holding rank. While `oe_n` is 1, `par_drive` is all zeros, meaning every parallel pin is high-impedance.
- R7: `oe_n` has no effect on `ser_out`, on the chain or on the holding rank. A store made while the outputs are disabled appears as soon as they are enabled again.
- R8: A strobe held high for any number of cycles causes exactly one shift or store. A new action needs the strobe to go low and then high again.
- R9: If `clr_n` is low while a shift edge is detected, the clear wins and the chain stays zero.
- R10: With two instances chained `ser_out` to `ser_in`, 2×`WIDTH` shifts followed by one store leave the first bit shifted in at the last stage of the downstream instance, and the last bit shifted in at stage 0 of the upstream instance.
- R11: After `rst_n`, the chain, the holding rank and `ser_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low system reset for every register |
| clr_n | input | 1 | Asynchronous active-low clear of the shift chain only |
| ser_in | input | 1 | Serial data into chain stage 0 |
| shift_clk | input | 1 | Shift strobe; each rising edge causes one shift |
| store_clk | input | 1 | Store strobe; each rising edge copies the chain to the holding rank |
| oe_n | input | 1 | Active-low parallel output enable |
| par_data | output | WIDTH | Holding rank contents |
| par_drive | output | WIDTH | Per-bit drive enable; 0 means the pin is high-impedance |
| ser_out | output | 1 | Last chain stage, for cascading |

## Verification
The hardest case to reach from the ports is a clear that lands while a shift is in progress. The strobe has to be detected while `clr_n` is held low, so that the chain cannot move, and the holding rank must still show its older word afterwards. The bench raises the clear first, then runs a full strobe cycle underneath it. After that it reads the chain back through a store, and reads the holding rank through the parallel outputs before and after re-enabling them. The rest of the stimulus is one sweep of all 256 byte values through the default eight-stage configuration. The bench checks every store against the expected byte. Several tied-strobe shifts then confirm the one-bit lag, and a 16-bit cascade run is compared against a bit queue.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Two-state strobe edge machine
    typedef enum logic [0:0] {
        ARMED = 1'b0,   // waiting for the synchronized strobe to go high
        SPENT = 1'b1    // pulse already issued, waiting for the strobe to drop
    } strobe_state_e;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import sipo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pulse_o
);

    localparam int SYNC_W = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

    logic [SYNC_W-1:0] sync_q;
    logic              level;
    strobe_state_e     state_q;
    strobe_state_e     state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_W-2:0], pin_i};
        end
    end

    assign level = sync_q[SYNC_W-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARMED:   if (level)  state_d = SPENT;
            SPENT:   if (!level) state_d = ARMED;
            default: state_d = ARMED;
        endcase
    end

    // outputs
    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            ARMED:   pulse_o = level;
            SPENT:   pulse_o = 1'b0;
            default: pulse_o = 1'b0;
        endcase
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             shift_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] stages_o
);

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] moved;

    assign moved = {stage_q[WIDTH-2:0], din_i};

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (!clr_n) begin
            stage_q <= '0;
        end else if (shift_i) begin
            stage_q <= moved;
        end
    end

    assign stages_o = stage_q;

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        shift_i |=> stages_o == $past({stages_o[WIDTH-2:0], din_i}));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && shift_i) |-> stages_o == '0);

endmodule

// File: rtl/hold_rank.sv
module hold_rank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_i,
    input  logic [WIDTH-1:0] stages_i,
    output logic [WIDTH-1:0] hold_o
);

    logic [WIDTH-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (store_i) begin
            hold_q <= stages_i;
        end
    end

    assign hold_o = hold_q;

    // R2
    store_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_i |=> hold_o == $past(stages_i));

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store_i |=> $stable(hold_o));

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
    import sipo_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_data,
    output logic [WIDTH-1:0] par_drive,
    output logic             ser_out
);

    localparam int TAP = WIDTH - 1;

    logic             shift_pulse;
    logic             store_pulse;
    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] hold;

    strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_shift_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (shift_clk),
        .pulse_o (shift_pulse)
    );

    strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_store_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (store_clk),
        .pulse_o (store_pulse)
    );

    shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .shift_i  (shift_pulse),
        .din_i    (ser_in),
        .stages_o (stages)
    );

    hold_rank #(.WIDTH(WIDTH)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .store_i  (store_pulse),
        .stages_i (stages),
        .hold_o   (hold)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign par_data[i]  = hold[i];
        assign par_drive[i] = ~oe_n;
    end

    assign ser_out = stages[TAP];

    // R5
    serial_tap_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        shift_pulse |=> ser_out == $past(stages[TAP-1]));

    // R3
    tied_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && store_pulse) |=> par_data == $past(stages));

endmodule

// File: tb/sipo_latch_reg_test.sv
module sipo_latch_reg_test;

    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n  = 1'b1;
    logic clr_n  = 1'b1;
    logic ser_in = 1'b0;
    logic sh     = 1'b0;
    logic st     = 1'b0;
    logic oe_n   = 1'b0;

    logic [W-1:0] d0, e0, d1, e1;
    logic         so0, so1;

    int  nvec = 0;
    int  nbad = 0;
    bit  done = 0;

    logic [2*W-1:0] m_chain = '0;
    logic [W-1:0]   m_hold  = '0;
    logic [W-1:0]   m_holdt = '0;

    sipo_latch_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(ser_in),
        .shift_clk(sh), .store_clk(st), .oe_n(oe_n),
        .par_data(d0), .par_drive(e0), .ser_out(so0)
    );

    sipo_latch_reg #(.WIDTH(W)) uut_tail (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ser_in(so0),
        .shift_clk(sh), .store_clk(st), .oe_n(oe_n),
        .par_data(d1), .par_drive(e1), .ser_out(so1)
    );

    task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic do_sh, input logic do_st, input logic b);
        @(negedge clk);
        ser_in = b; sh = do_sh; st = do_st;
        repeat (4) @(negedge clk);
        sh = 1'b0; st = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_shift(input logic b);
        strobe(1'b1, 1'b0, b);
        m_chain = {m_chain[2*W-2:0], b};
    endtask

    task automatic do_store();
        strobe(1'b0, 1'b1, ser_in);
        m_hold  = m_chain[W-1:0];
        m_holdt = m_chain[2*W-1:W];
    endtask

    task automatic do_both(input logic b);
        strobe(1'b1, 1'b1, b);
        m_hold  = m_chain[W-1:0];
        m_holdt = m_chain[2*W-1:W];
        m_chain = {m_chain[2*W-2:0], b};
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_n = 1'b0;
        #2;
        chk("R4 ser_out after clear", {15'd0, so0}, 16'd0);
        @(negedge clk);
        clr_n = 1'b1;
        m_chain = '0;
    endtask

    task automatic load_byte(input logic [W-1:0] v);
        for (int k = W - 1; k >= 0; k--) do_shift(v[k]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            nvec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 par_data", {8'd0, d0}, 16'd0);
        chk("R11 ser_out", {15'd0, so0}, 16'd0);
        chk("R6 drive enabled", {8'd0, e0}, {8'd0, {W{1'b1}}});

        // R1 R2 R5: sweep of every byte value
        for (int v = 0; v < 256; v++) begin
            for (int k = W - 1; k >= 0; k--) begin
                do_shift(v[k]);
                chk("R5 ser_out", {15'd0, so0}, {15'd0, m_chain[W-1]});
            end
            do_store();
            chk("R2 stored byte", {8'd0, d0}, v[15:0]);
            chk("R1 tail hold", {8'd0, d1}, {8'd0, m_holdt});
        end

        // R6 R7: outputs disabled
        oe_n = 1'b1;
        #2;
        chk("R6 drive off", {8'd0, e0}, 16'd0);
        do_shift(1'b1);
        oe_n = 1'b0;
        #2;
        chk("R7 ser_out with oe toggled", {15'd0, so0}, {15'd0, m_chain[W-1]});
        chk("R7 hold not touched by oe", {8'd0, d0}, {8'd0, m_hold});
        oe_n = 1'b1;
        do_store();
        chk("R6 still floating", {8'd0, e0}, 16'd0);
        oe_n = 1'b0;
        #2;
        chk("R7 store under disable", {8'd0, d0}, {8'd0, m_hold});

        // R4: clear leaves holding rank alone
        do_clear();
        load_byte(8'hA5);
        do_store();
        load_byte(8'h3C);
        oe_n = 1'b1;
        do_clear();
        chk("R6 floating during clear", {8'd0, e0}, 16'd0);
        oe_n = 1'b0;
        #2;
        chk("R4 hold kept", {8'd0, d0}, 16'h00A5);
        do_store();
        chk("R4 chain zeroed", {8'd0, d0}, 16'd0);

        // R9: shift under clear
        load_byte(8'hFF);
        @(negedge clk);
        clr_n = 1'b0;
        strobe(1'b1, 1'b0, 1'b1);
        chk("R9 ser_out during clear", {15'd0, so0}, 16'd0);
        clr_n = 1'b1;
        m_chain = '0;
        do_store();
        chk("R9 chain stays zero", {8'd0, d0}, 16'd0);

        // R8: long strobe gives one shift
        @(negedge clk);
        ser_in = 1'b1; sh = 1'b1;
        repeat (20) @(negedge clk);
        sh = 1'b0;
        repeat (4) @(negedge clk);
        m_chain = {m_chain[2*W-2:0], 1'b1};
        do_store();
        chk("R8 single shift", {8'd0, d0}, 16'h0001);

        // R3: tied strobes lag by one shift
        do_clear();
        load_byte(8'hC3);
        do_store();
        for (int j = 0; j < 6; j++) begin
            do_both(j[0]);
            chk("R3 tied lag", {8'd0, d0}, {8'd0, m_hold});
        end

        // R10: cascade of two
        begin
            bit q[$];
            logic [W-1:0] exp_t, exp_h;
            do_clear();
            for (int j = 0; j < 2 * W; j++) q.push_back(((j * 5) % 3) == 1);
            for (int j = 0; j < 2 * W; j++) do_shift(q[j]);
            do_store();
            for (int k = 0; k < W; k++) begin
                exp_t[W-1-k] = q[k];
                exp_h[W-1-k] = q[W+k];
            end
            chk("R10 tail byte", {8'd0, d1}, {8'd0, exp_t});
            chk("R10 head byte", {8'd0, d0}, {8'd0, exp_h});
            chk("R10 tail ser_out", {15'd0, so1}, {15'd0, q[0]});
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule